// File: doc/BRIEF.md
# Adder-Subtractor with Carry and Overflow Flags

A combinational n-bit unit that adds or subtracts two operands on one shared ripple-carry datapath. A single mode input chooses the operation. Subtraction inverts the second operand bit by bit and feeds a carry-in of one, so the unit computes A + (NOT B) + 1. Every result comes with two flags. The carry flag is the carry out of the top bit and suits unsigned operands. The overflow flag reports a signed result that does not fit the width.

A build-time parameter switches the unit to one's complement arithmetic. In that variant the carry-in of the main pass is zero in both modes. The carry out of the main pass is then added back in a second, separate increment pass (end-around carry), so the design contains no combinational loop. Outputs follow the inputs with no clock and no registers.

Top module: `addsub_unit`

## Requirements
- R1: In two's complement build with subMode = 0, result equals (opA + opB) mod 2^WIDTH.
- R2: In two's complement build with subMode = 1, result equals (opA - opB) mod 2^WIDTH, formed as opA + (NOT opB) + 1. The carry out of the top bit is dropped and no correction step follows.
- R3: In two's complement build, carryFlag is the carry out of bit WIDTH-1. After an addition it is 1 exactly when the unsigned sum reaches 2^WIDTH. After a subtraction it is 1 exactly when opA >= opB as unsigned values, so 0 means a borrow.
- R4: In two's complement build, ovfFlag is the carry into bit WIDTH-1 XOR the carry out of it. It is 1 exactly when the signed result lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. For 8 bits, 70+80 and (-70)+(-80) both set it.
- R5: ovfFlag stays 0 when an addition has operands of opposite sign (bit WIDTH-1 differs), or when a subtraction has operands of equal sign.
- R6: In one's complement build, the main pass adds opA and Y with carry-in 0, where Y = opB XOR subMode on every bit. The carry out of that pass is added to the pass sum by a second pass, and result is that second sum mod 2^WIDTH.
- R7: In one's complement build, carryFlag is the carry out of the main pass. Subtracting a value from itself gives all ones (negative zero) with carryFlag = 0.
- R8: In one's complement build, ovfFlag is 1 exactly when opA and Y have the same bit WIDTH-1 and result's bit WIDTH-1 differs from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand (minuend when subtracting) |
| opB | input | WIDTH | Second operand (subtrahend when subtracting) |
| subMode | input | 1 | 0 adds, 1 subtracts |
| result | output | WIDTH | Sum or difference |
| carryFlag | output | 1 | Carry out of the top bit; after subtraction, 1 means no borrow |
| ovfFlag | output | 1 | Signed overflow |

## Verification
The in-line checks assume the operand and mode inputs are two-state and settled when they are evaluated. A check on the result word also applies only to the arithmetic variant chosen at build time.

The bench drives both build variants side by side from the same vectors. It changes inputs only on the falling clock edge and reads the outputs a short delay later, so every check sees settled values. It covers the overflow corners (+70+80, -70-80, 0 minus -128), equal-operand subtraction, the all-ones carry wrap, and a long run of random operands in both modes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  // Strobes from the mode decoder to the arithmetic datapath.
  typedef struct packed {
    logic invertB;    // XOR the second operand with ones
    logic carryIn;    // carry fed into bit 0 of the main pass
    logic endAround;  // add the main-pass carry-out in a second pass
  } ctrl_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
#(
  parameter bit ONES_COMP = 1'b0
) (
  input  logic  subMode,
  output ctrl_t ctrl
);
  generate
    if (ONES_COMP) begin : g_ones
      assign ctrl.carryIn   = 1'b0;
      assign ctrl.endAround = 1'b1;
    end else begin : g_twos
      assign ctrl.carryIn   = subMode;
      assign ctrl.endAround = 1'b0;
    end
  endgenerate

  assign ctrl.invertB = subMode;

  // The one's complement variant never seeds the main pass with a carry.
  always_comb begin
    if (ctrl.endAround)
      AST_NO_SEED_CARRY: assert (ctrl.carryIn == 1'b0); // R6
  end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrl_t            ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             ovfFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opY;
  logic [WIDTH-1:0] passSum;
  logic [WIDTH:0]   carry;
  logic             wrapBit;
  logic             signRuleOvf;

  assign opY      = opB ^ {WIDTH{ctrl.invertB}};
  assign carry[0] = ctrl.carryIn;

  // Main pass: one full-adder cell per bit position.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      assign passSum[i]  = opA[i] ^ opY[i] ^ carry[i];
      assign carry[i+1]  = (opA[i] & opY[i]) | (carry[i] & (opA[i] ^ opY[i]));
    end
  endgenerate

  // Second pass: increment by the end-around carry when enabled.
  assign wrapBit = ctrl.endAround & carry[WIDTH];
  assign result  = passSum + {{MSB{1'b0}}, wrapBit};

  assign carryFlag   = carry[WIDTH];
  assign signRuleOvf = (opA[MSB] == opY[MSB]) & (result[MSB] ^ opA[MSB]);
  assign ovfFlag     = ctrl.endAround ? signRuleOvf : (carry[MSB] ^ carry[WIDTH]);

  // The wrap increment can only land on a pass sum below all ones.
  always_comb begin
    if (wrapBit)
      AST_WRAP_FITS: assert (passSum != {WIDTH{1'b1}}); // R6
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit ONES_COMP = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             ovfFlag
);
  localparam int MSB = WIDTH - 1;

  ctrl_t ctrl;

  addsub_ctrl #(.ONES_COMP(ONES_COMP)) u_ctrl (
    .subMode (subMode),
    .ctrl    (ctrl)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA       (opA),
    .opB       (opB),
    .ctrl      (ctrl),
    .result    (result),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag)
  );

  always_comb begin
    if (!ONES_COMP && !subMode)
      AST_SUM_VALUE: assert (result == WIDTH'(opA + opB)); // R1
    if (!ONES_COMP && subMode)
      AST_DIFF_VALUE: assert (result == WIDTH'(opA - opB)); // R2
    if (!ONES_COMP && subMode)
      AST_BORROW_SENSE: assert (carryFlag == (opA >= opB)); // R3
    if (!subMode && (opA[MSB] != opB[MSB]))
      AST_NO_OVERFLOW: assert (!ovfFlag); // R5
    if (subMode && (opA[MSB] == opB[MSB]))
      AST_NO_OVERFLOW_SUB: assert (!ovfFlag); // R5
    if (ONES_COMP && subMode && (opA == opB))
      AST_NEG_ZERO: assert (result == {WIDTH{1'b1}} && !carryFlag); // R7
  end
endmodule

// File: tb/addsub_unit_test.sv
module addsub_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic       subMode = 1'b0;
  logic [7:0] resT, resO;
  logic       cT, cO, vT, vO;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  addsub_unit #(.WIDTH(8), .ONES_COMP(1'b0)) uut (
    .opA(opA), .opB(opB), .subMode(subMode),
    .result(resT), .carryFlag(cT), .ovfFlag(vT));

  addsub_unit #(.WIDTH(8), .ONES_COMP(1'b1)) uutOnes (
    .opA(opA), .opB(opB), .subMode(subMode),
    .result(resO), .carryFlag(cO), .ovfFlag(vO));

  // Behavioural reference: returns {carry, overflow, result}.
  function automatic logic [9:0] refTwos(int a, int b, bit s);
    int sum, sa, sb, exact;
    bit c, v;
    sum = s ? (a + (255 - b) + 1) : (a + b);
    c = (sum >= 256);
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    exact = s ? sa - sb : sa + sb;
    v = (exact > 127) || (exact < -128);
    return {c, v, 8'(sum % 256)};
  endfunction

  function automatic logic [9:0] refOnes(int a, int b, bit s);
    int y, sum, r;
    bit c, v;
    y = s ? (255 - b) : b;
    sum = a + y;
    c = (sum >= 256);
    r = (sum % 256) + (c ? 1 : 0);
    r = r % 256;
    v = ((a >= 128) == (y >= 128)) && ((r >= 128) != (a >= 128));
    return {c, v, 8'(r)};
  endfunction

  task automatic apply(string tag, logic [7:0] a, logic [7:0] b, bit s);
    logic [9:0] expT, expO;
    @(negedge clk);
    opA = a; opB = b; subMode = s;
    #1;
    expT = refTwos(int'(a), int'(b), s);
    expO = refOnes(int'(a), int'(b), s);
    vectors++;
    if ({cT, vT, resT} !== expT) begin
      miscompares++;
      $display("FAIL %s twos a=%02h b=%02h s=%0d: got c=%0b v=%0b r=%02h exp c=%0b v=%0b r=%02h",
               tag, a, b, s, cT, vT, resT, expT[9], expT[8], expT[7:0]);
    end
    vectors++;
    if ({cO, vO, resO} !== expO) begin
      miscompares++;
      $display("FAIL %s ones a=%02h b=%02h s=%0d: got c=%0b v=%0b r=%02h exp c=%0b v=%0b r=%02h",
               tag, a, b, s, cO, vO, resO, expO[9], expO[8], expO[7:0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: all-zero inputs give zero outputs (R1, R6)
    apply("R1", 8'h00, 8'h00, 1'b0);
    // R4: +70 + +80 and -70 + -80 both overflow
    apply("R4", 8'd70, 8'd80, 1'b0);
    apply("R4", 8'hBA, 8'hB0, 1'b0);
    // R3: carry on unsigned wrap, borrow sense on subtraction
    apply("R3", 8'hFF, 8'h01, 1'b0);
    apply("R2", 8'd5, 8'd3, 1'b0);
    apply("R2", 8'd5, 8'd3, 1'b1);
    apply("R3", 8'd3, 8'd5, 1'b1);
    // R4: 0 minus -128 overflows, -128 minus 1 overflows
    apply("R4", 8'h00, 8'h80, 1'b1);
    apply("R4", 8'h80, 8'h01, 1'b1);
    // R5: mixed-sign add and same-sign subtract never overflow
    apply("R5", 8'h7F, 8'h80, 1'b0);
    apply("R5", 8'h80, 8'hFF, 1'b1);
    // R7: self subtraction, negative zero in one's complement
    apply("R7", 8'h5A, 8'h5A, 1'b1);
    apply("R7", 8'h00, 8'h00, 1'b1);
    // R6: end-around carry path
    apply("R6", 8'hFE, 8'h03, 1'b0);
    apply("R6", 8'd9, 8'd4, 1'b1);
    // R8: one's complement overflow
    apply("R8", 8'd100, 8'd100, 1'b0);
    apply("R8", 8'h9B, 8'd100, 1'b1);
    // Random sweep in both modes (R1, R2, R3, R4, R6, R7, R8)
    for (int i = 0; i < 3000; i++) begin
      apply("R1_R2_R6_rand", 8'($urandom), 8'($urandom), 1'($urandom));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule